// File: doc/BRIEF.md
# Dual-Issue Pairing and Hazard Scoreboard

This block sits at the issue point of an in-order, two-wide pipeline. Each cycle it is offered up to two candidate instructions, the older in lane 0 and the younger in lane 1. It decides how many of them may leave. Its decision rests on three things: a short reservation table of future issue-slot, integer-unit and floating-point-unit usage, a result countdown for every architectural register, and the order and dependency between the two candidates. Decode, execution, branch resolution and register contents are handled elsewhere.

Each lane is a valid/ready stream. `c0_valid` and `c1_valid` offer a descriptor, and `issue_0` and `issue_1` are the matching ready/accept signals. A descriptor is consumed on a clock edge where both its valid and its grant are high. An offered descriptor that is not granted must be held unchanged. When lane 0 issues alone, the upstream shifts its lane-1 instruction into lane 0. `stall` is a plain status pin that shows a lane-0 instruction was offered and held back.

Top module: `dual_issue_sched`

## Requirements
- R1: Class codes are 0 integer, 1 load, 2 store, 3 branch, 4 flow, 5 call, 6 float and 7 paired-float. Length codes are 0 short (4 bytes), 1 medium (8 bytes) and 2 or 3 long (12 to 24 bytes). The length code matters only for the integer class. Any class may issue from either lane, and two independent instructions that use different units issue in the same cycle.
- R2: Branch and flow instructions occupy both issue slots in their issue cycle. Nothing pairs with them, and in lane 1 they never issue.
- R3: A call occupies both slots in its issue cycle and in the 7 cycles that follow, so no instruction issues in those cycles.
- R4: Integer, load and store instructions reserve the single integer unit one cycle after issue, so no two of them issue together. A medium integer instruction holds the unit for offsets 1 and 2. A long integer instruction holds it for offsets 1 through 4.
- R5: Float and paired-float instructions reserve the single floating-point unit one cycle after issue, so no two of them issue together. A paired-float holds the unit for offsets 1 and 2.
- R6: Medium integer and paired-float instructions hold one issue slot in the cycle after issue. Long integer instructions hold one slot for the 3 cycles after issue.
- R7: A short integer result is usable 2 cycles after issue by a float-class consumer and 1 cycle after issue by any other consumer. A medium integer result is usable after 2 cycles and a long integer result after 4 cycles, for every consumer.
- R8: A load result is usable 3 cycles after issue by a float-class consumer and 2 cycles after issue by any other consumer.
- R9: A float or paired-float result is usable 5 cycles after issue. A store consuming a float (not paired-float) result may issue after 4 cycles.
- R10: Issue is in order. Lane 1 issues only in a cycle where lane 0 issues, and never when it reads or writes the register that the lane-0 instruction writes. Only integer, load, float and paired-float instructions write a destination.
- R11: `stall` is high exactly when lane 0 offers an instruction and it is not granted. With lane 0 idle, nothing issues.
- R12: A synchronous active-high reset clears all countdowns and reservations. No grant or stall is given while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_valid | input | 1 | Lane-0 (older) candidate offered |
| c0_cls | input | 3 | Lane-0 class code |
| c0_len | input | 2 | Lane-0 length code |
| c0_dst | input | RW | Lane-0 destination register |
| c0_src_a | input | RW | Lane-0 first source register |
| c0_src_b | input | RW | Lane-0 second source register |
| c1_valid | input | 1 | Lane-1 (younger) candidate offered |
| c1_cls | input | 3 | Lane-1 class code |
| c1_len | input | 2 | Lane-1 length code |
| c1_dst | input | RW | Lane-1 destination register |
| c1_src_a | input | RW | Lane-1 first source register |
| c1_src_b | input | RW | Lane-1 second source register |
| issue_0 | output | 1 | Lane-0 grant (ready) |
| issue_1 | output | 1 | Lane-1 grant (ready) |
| stall | output | 1 | Lane-0 offered but held back |

## Verification
The assertions take the class and register fields as known values whenever reset is low. They also assume an ungranted descriptor stays stable, so that a call seen at a grant is the call that was consumed. The producer-to-consumer check further assumes the consumer in lane 0 follows a lane-0 producer from the previous cycle. The stimulus holds each descriptor across a whole cycle and changes it only at the falling edge. It inserts idle gaps long enough for every countdown and reservation to drain between scenarios, so every expected grant pattern follows from the requirements alone.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam int RSV_DEPTH = 8;
  localparam int CALL_HOLD = 8;
  localparam int CNT_W     = 3;
  localparam int LONG_HOLD = 4;

  typedef enum logic [2:0] {
    CL_INT    = 3'd0,
    CL_LOAD   = 3'd1,
    CL_STORE  = 3'd2,
    CL_BRANCH = 3'd3,
    CL_FLOW   = 3'd4,
    CL_CALL   = 3'd5,
    CL_FP     = 3'd6,
    CL_VFP    = 3'd7
  } icls_e;

  localparam logic [1:0] LEN_SHORT = 2'd0;
  localparam logic [1:0] LEN_MID   = 2'd1;

  typedef enum logic [1:0] {
    BY_NONE  = 2'd0,
    BY_NONFP = 2'd1,
    BY_STORE = 2'd2
  } byp_e;

  typedef struct packed {
    logic [RSV_DEPTH-1:0][1:0] slots;
    logic [RSV_DEPTH-1:0]      intu;
    logic [RSV_DEPTH-1:0]      fpu;
  } resv_t;

  function automatic logic is_float(icls_e c);
    return (c == CL_FP) || (c == CL_VFP);
  endfunction

  function automatic logic uses_int(icls_e c);
    return (c == CL_INT) || (c == CL_LOAD) || (c == CL_STORE);
  endfunction

  function automatic logic writes_dst(icls_e c);
    return (c == CL_INT) || (c == CL_LOAD) || is_float(c);
  endfunction

  function automatic int int_hold(logic [1:0] len);
    if (len == LEN_SHORT) return 1;
    if (len == LEN_MID)   return 2;
    return LONG_HOLD;
  endfunction

  function automatic resv_t resv_pattern(icls_e c, logic [1:0] len);
    resv_t p;
    int    h;
    p = '0;
    h = int_hold(len);
    for (int k = 0; k < RSV_DEPTH; k++) begin
      case (c)
        CL_INT: begin
          if (k < h)             p.slots[k] = 2'd1;
          if (k >= 1 && k <= h)  p.intu[k]  = 1'b1;
        end
        CL_LOAD, CL_STORE: begin
          if (k == 0) p.slots[k] = 2'd1;
          if (k == 1) p.intu[k]  = 1'b1;
        end
        CL_BRANCH, CL_FLOW: begin
          if (k == 0) p.slots[k] = 2'd2;
        end
        CL_CALL: begin
          if (k < CALL_HOLD) p.slots[k] = 2'd2;
        end
        CL_FP: begin
          if (k == 0) p.slots[k] = 2'd1;
          if (k == 1) p.fpu[k]   = 1'b1;
        end
        default: begin
          if (k < 2)            p.slots[k] = 2'd1;
          if (k >= 1 && k <= 2) p.fpu[k]   = 1'b1;
        end
      endcase
    end
    return p;
  endfunction

  function automatic resv_t resv_merge(resv_t a, resv_t b);
    resv_t m;
    for (int k = 0; k < RSV_DEPTH; k++) m.slots[k] = a.slots[k] + b.slots[k];
    m.intu = a.intu | b.intu;
    m.fpu  = a.fpu | b.fpu;
    return m;
  endfunction

  function automatic resv_t resv_shift(resv_t a);
    resv_t s;
    s.slots = {2'b00, a.slots[RSV_DEPTH-1:1]};
    s.intu  = {1'b0, a.intu[RSV_DEPTH-1:1]};
    s.fpu   = {1'b0, a.fpu[RSV_DEPTH-1:1]};
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] result_lat(icls_e c, logic [1:0] len);
    case (c)
      CL_INT:  return (len == LEN_SHORT || len == LEN_MID) ? CNT_W'(2) : CNT_W'(4);
      CL_LOAD: return CNT_W'(3);
      default: return CNT_W'(5);
    endcase
  endfunction

  function automatic byp_e result_byp(icls_e c, logic [1:0] len);
    case (c)
      CL_INT:  return (len == LEN_SHORT) ? BY_NONFP : BY_NONE;
      CL_LOAD: return BY_NONFP;
      CL_FP:   return BY_STORE;
      default: return BY_NONE;
    endcase
  endfunction

endpackage

// File: rtl/isu_resv_table.sv
module isu_resv_table
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  resv_t add0,
  input  resv_t add1,
  output resv_t cur
);

  resv_t tab_q;
  resv_t sum;

  always_comb sum = resv_merge(resv_merge(tab_q, add0), add1);

  always_ff @(posedge clk) begin
    if (rst) tab_q <= '0;
    else     tab_q <= resv_shift(sum);
  end

  assign cur = tab_q;

endmodule

// File: rtl/isu_fit.sv
module isu_fit
  import isu_pkg::*;
(
  input  resv_t base,
  input  resv_t req,
  output logic  fit
);

  always_comb begin
    fit = 1'b1;
    for (int k = 0; k < RSV_DEPTH; k++) begin
      if (({1'b0, base.slots[k]} + {1'b0, req.slots[k]}) > 3'd2) fit = 1'b0;
    end
    if ((base.intu & req.intu) != '0) fit = 1'b0;
    if ((base.fpu & req.fpu) != '0)   fit = 1'b0;
  end

endmodule

// File: rtl/isu_reg_timer.sv
module isu_reg_timer
  import isu_pkg::*;
#(
  parameter int NREG = 64,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr0_en,
  input  logic [RW-1:0]              wr0_dst,
  input  logic [CNT_W-1:0]           wr0_lat,
  input  logic [1:0]                 wr0_byp,
  input  logic                       wr1_en,
  input  logic [RW-1:0]              wr1_dst,
  input  logic [CNT_W-1:0]           wr1_lat,
  input  logic [1:0]                 wr1_byp,
  output logic [NREG-1:0][CNT_W-1:0] cnt_o,
  output logic [NREG-1:0][1:0]       byp_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       byp_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        byp_q <= '0;
      end else if (wr1_en && wr1_dst == RW'(g)) begin
        cnt_q <= wr1_lat - CNT_W'(1);
        byp_q <= wr1_byp;
      end else if (wr0_en && wr0_dst == RW'(g)) begin
        cnt_q <= wr0_lat - CNT_W'(1);
        byp_q <= wr0_byp;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end

    assign cnt_o[g] = cnt_q;
    assign byp_o[g] = byp_q;
  end

endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import isu_pkg::*;
#(
  parameter int NREG = 64,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c0_valid,
  input  logic [2:0]    c0_cls,
  input  logic [1:0]    c0_len,
  input  logic [RW-1:0] c0_dst,
  input  logic [RW-1:0] c0_src_a,
  input  logic [RW-1:0] c0_src_b,
  input  logic          c1_valid,
  input  logic [2:0]    c1_cls,
  input  logic [1:0]    c1_len,
  input  logic [RW-1:0] c1_dst,
  input  logic [RW-1:0] c1_src_a,
  input  logic [RW-1:0] c1_src_b,
  output logic          issue_0,
  output logic          issue_1,
  output logic          stall
);

  icls_e cls0, cls1;
  resv_t pat0, pat1, table_now, base1, add0, add1;
  logic  fit0, fit1, src_ok0, src_ok1, dep1;

  logic [NREG-1:0][CNT_W-1:0] reg_cnt;
  logic [NREG-1:0][1:0]       reg_byp;

  assign cls0 = icls_e'(c0_cls);
  assign cls1 = icls_e'(c1_cls);

  function automatic logic src_ready(logic [CNT_W-1:0] cnt, logic [1:0] byp, icls_e cons);
    logic early;
    early = ((byp == BY_NONFP) && !is_float(cons)) ||
            ((byp == BY_STORE) && (cons == CL_STORE));
    return (cnt == '0) || ((cnt == CNT_W'(1)) && early);
  endfunction

  always_comb begin
    pat0 = resv_pattern(cls0, c0_len);
    pat1 = resv_pattern(cls1, c1_len);
  end

  isu_fit i_fit0 (.base(table_now), .req(pat0), .fit(fit0));

  always_comb base1 = issue_0 ? resv_merge(table_now, pat0) : table_now;

  isu_fit i_fit1 (.base(base1), .req(pat1), .fit(fit1));

  always_comb begin
    src_ok0 = src_ready(reg_cnt[c0_src_a], reg_byp[c0_src_a], cls0) &&
              src_ready(reg_cnt[c0_src_b], reg_byp[c0_src_b], cls0);
    src_ok1 = src_ready(reg_cnt[c1_src_a], reg_byp[c1_src_a], cls1) &&
              src_ready(reg_cnt[c1_src_b], reg_byp[c1_src_b], cls1);
    dep1    = writes_dst(cls0) &&
              ((c1_src_a == c0_dst) || (c1_src_b == c0_dst) ||
               (writes_dst(cls1) && (c1_dst == c0_dst)));
  end

  always_comb begin
    issue_0 = !rst && c0_valid && fit0 && src_ok0;
    issue_1 = issue_0 && c1_valid && fit1 && src_ok1 && !dep1;
    stall   = !rst && c0_valid && !issue_0;
    add0    = issue_0 ? pat0 : '0;
    add1    = issue_1 ? pat1 : '0;
  end

  isu_resv_table i_table (
    .clk (clk),
    .rst (rst),
    .add0(add0),
    .add1(add1),
    .cur (table_now)
  );

  isu_reg_timer #(.NREG(NREG), .RW(RW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .wr0_en (issue_0 && writes_dst(cls0)),
    .wr0_dst(c0_dst),
    .wr0_lat(result_lat(cls0, c0_len)),
    .wr0_byp(result_byp(cls0, c0_len)),
    .wr1_en (issue_1 && writes_dst(cls1)),
    .wr1_dst(c1_dst),
    .wr1_lat(result_lat(cls1, c1_len)),
    .wr1_byp(result_byp(cls1, c1_len)),
    .cnt_o  (reg_cnt),
    .byp_o  (reg_byp)
  );

endmodule

// File: rtl/isu_chk.sv
module isu_chk
  import isu_pkg::*;
#(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    c0_cls,
  input logic [1:0]    c0_len,
  input logic [RW-1:0] c0_dst,
  input logic [RW-1:0] c0_src_a,
  input logic [RW-1:0] c0_src_b,
  input logic [2:0]    c1_cls,
  input logic [RW-1:0] c1_src_a,
  input logic [RW-1:0] c1_src_b,
  input logic          issue_0,
  input logic          issue_1
);

  localparam int HW = $clog2(CALL_HOLD) + 1;

  logic [HW-1:0] hold_q;
  icls_e k0, k1;

  assign k0 = icls_e'(c0_cls);
  assign k1 = icls_e'(c1_cls);

  always_ff @(posedge clk) begin
    if (rst)                             hold_q <= '0;
    else if (issue_0 && k0 == CL_CALL)   hold_q <= HW'(CALL_HOLD - 1);
    else if (hold_q != '0)               hold_q <= hold_q - HW'(1);
  end

  AST_LOCK_SOLO: assert property (@(posedge clk) disable iff (rst)
    issue_0 && (k0 == CL_BRANCH || k0 == CL_FLOW || k0 == CL_CALL) |-> !issue_1); // R2

  AST_LANE1_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    issue_1 |-> !(k1 == CL_BRANCH || k1 == CL_FLOW || k1 == CL_CALL)); // R2

  AST_CALL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0) |-> !issue_0); // R3

  AST_INT_UNIT_PAIR: assert property (@(posedge clk) disable iff (rst)
    issue_1 |-> !(uses_int(k0) && uses_int(k1))); // R4

  AST_FPU_PAIR: assert property (@(posedge clk) disable iff (rst)
    issue_1 |-> !(is_float(k0) && is_float(k1))); // R5

  AST_SHORT_INT_TO_FP: assert property (@(posedge clk) disable iff (rst)
    !(issue_0 && is_float(k0) &&
      $past(issue_0 && k0 == CL_INT && c0_len == LEN_SHORT) &&
      (c0_src_a == $past(c0_dst) || c0_src_b == $past(c0_dst)))); // R7

  AST_LANE1_RAW: assert property (@(posedge clk) disable iff (rst)
    issue_1 && writes_dst(k0) |-> (c1_src_a != c0_dst) && (c1_src_b != c0_dst)); // R10

endmodule

bind dual_issue_sched isu_chk #(.RW(RW)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .c0_cls  (c0_cls),
  .c0_len  (c0_len),
  .c0_dst  (c0_dst),
  .c0_src_a(c0_src_a),
  .c0_src_b(c0_src_b),
  .c1_cls  (c1_cls),
  .c1_src_a(c1_src_a),
  .c1_src_b(c1_src_b),
  .issue_0 (issue_0),
  .issue_1 (issue_1)
);

// File: tb/test_dual_issue_sched.sv
module test_dual_issue_sched;

  localparam int CLK_P = 10;
  localparam int RW    = 6;

  localparam logic [2:0] INT = 3'd0, LD = 3'd1, ST = 3'd2, BR = 3'd3,
                         FL = 3'd4, CA = 3'd5, FP = 3'd6, VF = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c0_valid = 1'b0, c1_valid = 1'b0;
  logic [2:0] c0_cls = '0, c1_cls = '0;
  logic [1:0] c0_len = '0, c1_len = '0;
  logic [RW-1:0] c0_dst = '0, c0_src_a = '0, c0_src_b = '0;
  logic [RW-1:0] c1_dst = '0, c1_src_a = '0, c1_src_b = '0;
  logic issue_0, issue_1, stall;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_issue_sched #(.NREG(64), .RW(RW)) i_dual_issue_sched (
    .clk(clk), .rst(rst),
    .c0_valid(c0_valid), .c0_cls(c0_cls), .c0_len(c0_len),
    .c0_dst(c0_dst), .c0_src_a(c0_src_a), .c0_src_b(c0_src_b),
    .c1_valid(c1_valid), .c1_cls(c1_cls), .c1_len(c1_len),
    .c1_dst(c1_dst), .c1_src_a(c1_src_a), .c1_src_b(c1_src_b),
    .issue_0(issue_0), .issue_1(issue_1), .stall(stall)
  );

  task automatic put0(logic v, logic [2:0] c, logic [1:0] l, int d, int a, int b);
    c0_valid = v; c0_cls = c; c0_len = l;
    c0_dst = RW'(d); c0_src_a = RW'(a); c0_src_b = RW'(b);
  endtask

  task automatic put1(logic v, logic [2:0] c, logic [1:0] l, int d, int a, int b);
    c1_valid = v; c1_cls = c; c1_len = l;
    c1_dst = RW'(d); c1_src_a = RW'(a); c1_src_b = RW'(b);
  endtask

  // expected code is {stall, issue_1, issue_0}; check then advance one cycle
  task automatic cyc(string tag, logic [2:0] exp);
    logic [2:0] act;
    #1;
    act = {stall, issue_1, issue_0};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stall,issue_1,issue_0} actual %b expected %b", tag, act, exp);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    put0(0, INT, 0, 0, 0, 0);
    put1(0, INT, 0, 0, 0, 0);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    idle(1);
    cyc("R12 idle after reset", 3'b000);
    put0(0, INT, 0, 1, 2, 3); put1(1, FP, 0, 4, 5, 6);
    cyc("R11 lane 1 alone does not issue", 3'b000);
    idle(2);
  endtask

  task automatic t_pairing;
    put0(1, INT, 0, 1, 2, 3); put1(1, FP, 0, 4, 5, 6);
    cyc("R1 int with float pairs", 3'b011);
    idle(6);
    put0(1, FP, 0, 7, 8, 9); put1(1, LD, 0, 10, 11, 12);
    cyc("R1 float with load pairs", 3'b011);
    idle(6);
    put0(1, INT, 0, 13, 14, 15); put1(1, LD, 0, 16, 17, 18);
    cyc("R4 int with load no pair", 3'b001);
    idle(6);
    put0(1, ST, 0, 0, 14, 15); put1(1, INT, 0, 19, 17, 18);
    cyc("R4 store with int no pair", 3'b001);
    idle(6);
    put0(1, FP, 0, 20, 21, 22); put1(1, VF, 0, 23, 24, 25);
    cyc("R5 float with paired-float no pair", 3'b001);
    idle(8);
  endtask

  task automatic t_lock;
    put0(1, BR, 0, 0, 1, 2); put1(1, FP, 0, 3, 4, 5);
    cyc("R2 branch in lane 0 alone", 3'b001);
    idle(3);
    put0(1, FP, 0, 6, 7, 8); put1(1, FL, 0, 0, 1, 2);
    cyc("R2 flow in lane 1 not issued", 3'b001);
    idle(8);
  endtask

  task automatic t_call;
    put0(1, CA, 0, 0, 1, 2); put1(0, INT, 0, 0, 0, 0);
    cyc("R3 call issues", 3'b001);
    put0(1, INT, 0, 30, 31, 32);
    for (int i = 0; i < 7; i++) cyc("R3 blocked after call", 3'b100);
    cyc("R3 free after call window", 3'b001);
    idle(8);
  endtask

  task automatic t_holds;
    put0(1, INT, 1, 10, 1, 2);
    cyc("R6 medium int issues", 3'b001);
    put0(1, BR, 0, 0, 3, 4);
    cyc("R6 slot held so branch waits", 3'b100);
    cyc("R6 branch after hold", 3'b001);
    idle(8);
    put0(1, VF, 0, 11, 1, 2);
    cyc("R5 paired-float issues", 3'b001);
    put0(1, FP, 0, 12, 13, 14);
    cyc("R5 fpu held second cycle", 3'b100);
    cyc("R5 float after fpu hold", 3'b001);
    idle(8);
    put0(1, INT, 2, 15, 1, 2);
    cyc("R4 long int issues", 3'b001);
    put0(1, INT, 0, 16, 17, 18);
    for (int i = 0; i < 3; i++) cyc("R4 int unit held by long int", 3'b100);
    cyc("R4 int after long hold", 3'b001);
    idle(8);
  endtask

  task automatic t_int_lat;
    put0(1, INT, 0, 5, 1, 2);
    cyc("R7 short int producer", 3'b001);
    put0(1, ST, 0, 0, 5, 3);
    cyc("R7 bypass to store after 1", 3'b001);
    idle(8);
    put0(1, INT, 0, 5, 1, 2);
    cyc("R7 short int producer", 3'b001);
    put0(1, FP, 0, 6, 5, 3);
    cyc("R7 float consumer waits", 3'b100);
    cyc("R7 float consumer after 2", 3'b001);
    idle(8);
    put0(1, INT, 2, 20, 1, 2);
    cyc("R7 long int producer", 3'b001);
    put0(1, FP, 0, 21, 20, 3);
    for (int i = 0; i < 3; i++) cyc("R7 long result pending", 3'b100);
    cyc("R7 long result after 4", 3'b001);
    idle(8);
  endtask

  task automatic t_load_lat;
    put0(1, LD, 0, 6, 1, 2);
    cyc("R8 load producer", 3'b001);
    put0(1, INT, 0, 7, 6, 3);
    cyc("R8 int consumer waits", 3'b100);
    cyc("R8 int consumer after 2", 3'b001);
    idle(8);
    put0(1, LD, 0, 6, 1, 2);
    cyc("R8 load producer", 3'b001);
    put0(1, FP, 0, 7, 3, 6);
    cyc("R8 float consumer waits", 3'b100);
    cyc("R8 float consumer waits", 3'b100);
    cyc("R8 float consumer after 3", 3'b001);
    idle(8);
  endtask

  task automatic t_fp_lat;
    put0(1, FP, 0, 7, 1, 2);
    cyc("R9 float producer", 3'b001);
    put0(1, ST, 0, 0, 7, 3);
    for (int i = 0; i < 3; i++) cyc("R9 store waits", 3'b100);
    cyc("R9 store after 4", 3'b001);
    idle(8);
    put0(1, FP, 0, 7, 1, 2);
    cyc("R9 float producer", 3'b001);
    put0(1, INT, 0, 8, 7, 3);
    for (int i = 0; i < 4; i++) cyc("R9 int waits", 3'b100);
    cyc("R9 int after 5", 3'b001);
    idle(8);
    put0(1, VF, 0, 9, 1, 2);
    cyc("R9 paired-float producer", 3'b001);
    put0(1, ST, 0, 0, 9, 3);
    for (int i = 0; i < 4; i++) cyc("R9 store waits on paired-float", 3'b100);
    cyc("R9 store after 5", 3'b001);
    idle(8);
  endtask

  task automatic t_order;
    put0(1, INT, 0, 3, 1, 2); put1(1, FP, 0, 40, 3, 4);
    cyc("R10 lane 1 reads lane 0 dest", 3'b001);
    idle(8);
    put0(1, INT, 0, 3, 1, 2); put1(1, FP, 0, 41, 42, 43);
    cyc("R10 independent lane 1 issues", 3'b011);
    idle(8);
    put0(1, INT, 0, 25, 1, 2); put1(1, FP, 0, 25, 42, 43);
    cyc("R10 same dest blocks lane 1", 3'b001);
    idle(8);
    put0(1, LD, 0, 4, 1, 2); put1(0, INT, 0, 0, 0, 0);
    cyc("R10 load producer", 3'b001);
    put0(1, INT, 0, 44, 4, 1); put1(1, FP, 0, 45, 46, 47);
    cyc("R11 lane 0 stalls and lane 1 held", 3'b100);
    idle(8);
  endtask

  task automatic t_mid_reset;
    put0(1, LD, 0, 2, 1, 3);
    cyc("R12 load before reset", 3'b001);
    rst = 1'b1;
    put0(1, FP, 0, 5, 2, 3);
    cyc("R12 no grant during reset", 3'b000);
    cyc("R12 no grant during reset", 3'b000);
    rst = 1'b0;
    cyc("R12 countdown cleared", 3'b001);
    idle(4);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_pairing();
    t_lock();
    t_call();
    t_holds();
    t_int_lat();
    t_load_lat();
    t_fp_lat();
    t_order();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule